// File: doc/BRIEF.md
# Comparison-Based Logic Self-Test Array

This block is a self-test harness for a row of identical small logic cells. A counter-based pattern generator feeds the same stimulus to every cell under test. Between each pair of neighbouring cells sits a comparator. It takes the diagonal-side output of the left cell and the direct-side output of the right cell, and sets a sticky flag when the two disagree. Each cell is a parameterized model built from two 3-input lookup tables and one flip-flop. Its truth tables, flip-flop preset value and output mode are set from a control register. All cells share that configuration.

The host drives the test one step at a time. Each write strobe on `host_wr_i` is exactly one test clock. After the run, the host sets the scan bit in the control register. The comparator flags then form a shift register in place, with their values kept. The host reads the flags one per strobe from `scan_o`, flag 0 first. The host may clear the flags before each configuration, or let them build up over several configurations. Building them up still finds every faulty cell, but it no longer shows which configuration failed. For verification, a fault input inverts the first lookup-table result of one selected cell.

Top module: `lbist_array`

## Requirements
- R1: After reset, all flags, both generator counters, every cell flip-flop and the stored control fields are 0, and `scan_o` is 0.
- R2: A control write loads `ctrl_data_i` with these fields: [7:0] truth table A, [15:8] truth table B, [16] scan mode, [17] flip-flop preset value, [18] registered-output mode. Bits [19] (restart) and [20] (flag clear) are pulses that act only in the write cycle and are not stored.
- R3: The generator holds a low and a high 5-bit counter, both cleared by restart. Each test step increments the low counter, and the high counter increments when the low counter wraps from 31 to 0.
- R4: Every cell sees the same pattern and configuration. Its first table gives `a = A[low[2:0]]`. Its second table gives `f = B[{a, high[0], q}]`, and each test step loads f into the cell flip-flop q. Both outputs carry f when bit 18 is 0 and q when it is 1.
- R5: A restart loads every cell flip-flop with the preset bit of the same write, which is either 0 or 1.
- R6: There are NUM_CELLS-1 comparators. Comparator k compares the diagonal output of cell k with the direct output of cell k+1.
- R7: On a test step, a comparator whose inputs differ sets its flag to 1. The flag holds until a flag-clear pulse or reset.
- R8: Only a `host_wr_i` strobe advances the test. Control writes and cycles without a strobe set no flag and step no counter.
- R9: If the flags are not cleared, mismatches from later configurations add to flags already set.
- R10: In scan mode, flags take no comparison results and the generator and cells are frozen. `scan_o` shows flag 0. Each strobe moves flag k+1 into flag k and shifts a 0 into the top flag. Entering scan mode leaves the flag values unchanged.
- R11: While `fault_en_i` is 1, the first-table result of cell `fault_sel_i` is inverted. Only the comparators next to that cell (k = sel-1 and k = sel, where they exist) can then flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_data_i | input | 21 | Control word (fields in R2) |
| host_wr_i | input | 1 | Host strobe: one test step, or one scan shift in scan mode |
| fault_en_i | input | 1 | Enable fault injection |
| fault_sel_i | input | $clog2(NUM_CELLS) | Index of the faulted cell |
| scan_o | output | 1 | Flag 0 in scan mode, 0 otherwise |

## Verification
The inline properties check the following on every cycle:
- a restart zeroes the counters and loads each flip-flop with the preset;
- the high counter steps exactly when the low counter wraps;
- a set flag stays set without a clear or shift;
- a clear empties the flags;
- in scan mode the pattern and flags stay still between strobes.

Other behaviour shows only through the bench scenarios, read serially through `scan_o`:
- which comparators report a fault at each position, including both ends of the row;
- the one-step delay that registered-output mode adds;
- the boundary at step 33, where the high counter bit first exposes a fault;
- flags building up across configurations;
- flag order and zero fill on the chain.

// File: rtl/lbist_pkg.sv
// Shared types for the logic self-test array.
// Assumes the control word layout below is fixed by the host software.
package lbist_pkg;

    localparam int CTRL_W = 21;

    // Control word, MSB first: pulses at [20:19], stored fields below.
    typedef struct packed {
        logic       flag_clr;   // [20] pulse: clear all flags
        logic       restart;    // [19] pulse: zero generator, preset cells
        logic       out_reg;    // [18] outputs from flip-flop instead of table B
        logic       preset;     // [17] flip-flop preset value for restart
        logic       scan;       // [16] flags form a shift chain
        logic [7:0] lut_b;      // [15:8] second table
        logic [7:0] lut_a;      // [7:0]  first table
    } ctrl_word_t;

endpackage

// File: rtl/lbist_patgen.sv
// Pattern generator: a low and a high counter cascaded into one stimulus word.
// Assumes step_i and restart_i are single-cycle qualified enables.
module lbist_patgen #(
    parameter int CNT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               restart_i,
    output logic [2*CNT_W-1:0] pat_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] lo_q;
    logic [CNT_W-1:0] hi_q;

    // Advance low counter each step; carry into high counter on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (step_i) begin
            lo_q <= lo_q + 1'b1;
            if (lo_q == CNT_MAX) hi_q <= hi_q + 1'b1;
        end
    end

    assign pat_o = {hi_q, lo_q};

    // R3
    gen_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (lo_q == '0 && hi_q == '0));

    // R3
    gen_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !restart_i && lo_q == CNT_MAX)
            |=> (lo_q == '0 && hi_q == $past(hi_q) + 1'b1));

endmodule

// File: rtl/lbist_cut.sv
// Model of one cell under test: two 3-input tables and one flip-flop.
// Assumes the table index bit order {a, high[0], q} for the second table.
module lbist_cut (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       restart_i,
    input  logic       preset_i,
    input  logic       out_reg_i,
    input  logic [7:0] lut_a_i,
    input  logic [7:0] lut_b_i,
    input  logic       fault_i,
    input  logic [2:0] sel_i,
    input  logic       hi_i,
    output logic       diag_o,
    output logic       direct_o
);
    logic       q;
    logic       a_val;
    logic       f_val;
    logic [2:0] b_idx;
    logic       out_val;

    // Evaluate both tables; the fault flips the first table result.
    always_comb begin
        a_val   = lut_a_i[sel_i] ^ fault_i;
        b_idx   = {a_val, hi_i, q};
        f_val   = lut_b_i[b_idx];
        out_val = out_reg_i ? q : f_val;
    end

    // Flip-flop: preset on restart, capture table B on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= 1'b0;
        else if (restart_i) q <= preset_i;
        else if (step_i)    q <= f_val;
    end

    assign diag_o   = out_val;
    assign direct_o = out_val;

    // R5
    cut_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (q == $past(preset_i)));

endmodule

// File: rtl/lbist_ora.sv
// Comparator cell: sticky mismatch flag that doubles as one scan stage.
// Assumes shift and step are never requested together by the top.
module lbist_ora (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    input  logic shift_i,
    input  logic diag_i,
    input  logic direct_i,
    input  logic shift_in_i,
    output logic flag_o
);
    // Clear, shift, or latch a mismatch seen on a test step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                  flag_o <= 1'b0;
        else if (shift_i)                     flag_o <= shift_in_i;
        else if (step_i && diag_i != direct_i) flag_o <= 1'b1;
    end

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i && !shift_i) |=> flag_o);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_o);

endmodule

// File: rtl/lbist_array.sv
// Top of the self-test array: generator, row of cells, comparators and scan chain.
// Assumes the host does not strobe host_wr_i in the same cycle as a control write.
module lbist_array #(
    parameter int NUM_CELLS = 8,
    parameter int CNT_W     = 5,
    localparam int SEL_W    = $clog2(NUM_CELLS),
    localparam int NUM_ORA  = NUM_CELLS - 1,
    localparam int PAT_W    = 2 * CNT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctrl_wr_i,
    input  logic [lbist_pkg::CTRL_W-1:0] ctrl_data_i,
    input  logic                      host_wr_i,
    input  logic                      fault_en_i,
    input  logic [SEL_W-1:0]          fault_sel_i,
    output logic                      scan_o
);
    import lbist_pkg::*;

    ctrl_word_t         ctrl_in;
    ctrl_word_t         ctrl_q;
    logic               restart_w;
    logic               clr_w;
    logic               step_w;
    logic               shift_w;
    logic [PAT_W-1:0]   pat;
    logic [NUM_CELLS-1:0] diag;
    logic [NUM_CELLS-1:0] direct;
    logic [NUM_ORA-1:0] flags;

    assign ctrl_in   = ctrl_word_t'(ctrl_data_i);
    assign restart_w = ctrl_wr_i & ctrl_in.restart;
    assign clr_w     = ctrl_wr_i & ctrl_in.flag_clr;
    assign step_w    = host_wr_i & ~ctrl_q.scan;
    assign shift_w   = host_wr_i &  ctrl_q.scan;

    // Store the persistent control fields; pulse bits are never held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr_i) begin
            ctrl_q          <= ctrl_in;
            ctrl_q.restart  <= 1'b0;
            ctrl_q.flag_clr <= 1'b0;
        end
    end

    lbist_patgen #(.CNT_W(CNT_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step_w),
        .restart_i(restart_w),
        .pat_o    (pat)
    );

    // One identically configured cell per position, all fed the same pattern.
    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        logic fault_here;
        assign fault_here = fault_en_i && (fault_sel_i == SEL_W'(c));
        lbist_cut u_cut (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_i   (step_w),
            .restart_i(restart_w),
            .preset_i (ctrl_in.preset),
            .out_reg_i(ctrl_q.out_reg),
            .lut_a_i  (ctrl_q.lut_a),
            .lut_b_i  (ctrl_q.lut_b),
            .fault_i  (fault_here),
            .sel_i    (pat[2:0]),
            .hi_i     (pat[CNT_W]),
            .diag_o   (diag[c]),
            .direct_o (direct[c])
        );
    end

    // Comparator k watches cell k diagonally and cell k+1 directly.
    for (genvar k = 0; k < NUM_ORA; k++) begin : g_ora
        logic chain_in;
        if (k == NUM_ORA - 1) begin : g_top
            assign chain_in = 1'b0;
        end else begin : g_mid
            assign chain_in = flags[k+1];
        end
        lbist_ora u_ora (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (clr_w),
            .step_i    (step_w),
            .shift_i   (shift_w),
            .diag_i    (diag[k]),
            .direct_i  (direct[k+1]),
            .shift_in_i(chain_in),
            .flag_o    (flags[k])
        );
    end

    assign scan_o = ctrl_q.scan & flags[0];

    // R10
    scan_pat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.scan && !restart_w) |=> $stable(pat));

    // R10
    scan_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.scan && !host_wr_i && !clr_w) |=> $stable(flags));

    // R8
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr_i && !clr_w) |=> $stable(flags));

endmodule

// File: tb/sim_lbist_array.sv
module sim_lbist_array;
    import lbist_pkg::*;

    localparam int N  = 8;
    localparam int NF = N - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr_i = 1'b0;
    logic [20:0] ctrl_data_i = '0;
    logic        host_wr_i = 1'b0;
    logic        fault_en_i = 1'b0;
    logic [2:0]  fault_sel_i = '0;
    logic        scan_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lbist_array #(.NUM_CELLS(N), .CNT_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr_i), .ctrl_data_i(ctrl_data_i),
        .host_wr_i(host_wr_i), .fault_en_i(fault_en_i), .fault_sel_i(fault_sel_i),
        .scan_o(scan_o)
    );

    typedef struct packed {
        logic       fen;
        logic [2:0] fsel;
        logic [7:0] la;
        logic [7:0] lb;
        logic       pre;
        logic       oreg;
        logic [5:0] steps;
        logic [6:0] expf;
    } vec_t;

    // Stimulus and expected flags; bit k of expf is comparator k.
    localparam vec_t TBL [11] = '{
        '{1'b1, 3'd3, 8'hFF, 8'hF0, 1'b0, 1'b0, 6'd1,  7'b0001100}, // R11 R6 middle
        '{1'b1, 3'd0, 8'hFF, 8'hF0, 1'b0, 1'b0, 6'd1,  7'b0000001}, // R11 left end
        '{1'b1, 3'd7, 8'hFF, 8'hF0, 1'b0, 1'b0, 6'd1,  7'b1000000}, // R11 right end
        '{1'b0, 3'd4, 8'hFF, 8'hF0, 1'b0, 1'b0, 6'd5,  7'b0000000}, // R4 healthy row
        '{1'b1, 3'd2, 8'hFF, 8'hC0, 1'b0, 1'b0, 6'd32, 7'b0000000}, // R3 high bit still 0
        '{1'b1, 3'd2, 8'hFF, 8'hC0, 1'b0, 1'b0, 6'd33, 7'b0000110}, // R3 carry exposes fault
        '{1'b1, 3'd5, 8'hFF, 8'hA0, 1'b0, 1'b0, 6'd4,  7'b0000000}, // R5 preset 0 masks
        '{1'b1, 3'd5, 8'hFF, 8'hA0, 1'b1, 1'b0, 6'd1,  7'b0110000}, // R5 preset 1 exposes
        '{1'b1, 3'd4, 8'hFF, 8'hF0, 1'b0, 1'b1, 6'd1,  7'b0000000}, // R4 registered delay
        '{1'b1, 3'd4, 8'hFF, 8'hF0, 1'b0, 1'b1, 6'd2,  7'b0011000}, // R4 registered mode
        '{1'b1, 3'd3, 8'hFF, 8'hF0, 1'b0, 1'b0, 6'd0,  7'b0000000}  // R8 no strobe
    };

    function automatic logic [20:0] mk(input logic clr, input logic rs, input logic oreg,
                                       input logic pre, input logic scan,
                                       input logic [7:0] lb, input logic [7:0] la);
        return {clr, rs, oreg, pre, scan, lb, la};
    endfunction

    task automatic wr_ctrl(input logic [20:0] d);
        ctrl_data_i = d; ctrl_wr_i = 1'b1;
        @(posedge clk); @(negedge clk);
        ctrl_wr_i = 1'b0;
    endtask

    task automatic strobe();
        host_wr_i = 1'b1;
        @(posedge clk); @(negedge clk);
        host_wr_i = 1'b0;
    endtask

    task automatic run_cfg(input logic clr, input logic fen, input logic [2:0] fsel,
                           input logic [7:0] la, input logic [7:0] lb, input logic pre,
                           input logic oreg, input int steps);
        wr_ctrl(mk(clr, 1'b1, oreg, pre, 1'b0, lb, la));
        fault_sel_i = fsel; fault_en_i = fen;
        for (int s = 0; s < steps; s++) strobe();
        fault_en_i = 1'b0;
    endtask

    // Enter scan mode, read flag 0 first, then leave scan mode.
    task automatic read_flags(output logic [6:0] got);
        wr_ctrl(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00));
        for (int i = 0; i < NF; i++) begin
            got[i] = scan_o;
            strobe();
        end
        wr_ctrl(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00));
    endtask

    task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [6:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of scan output and every flag
        check("R1 scan_o", {6'b0, scan_o}, 7'b0);
        read_flags(got);
        check("R1 flags", got, 7'b0);

        // R2 R4 R6 R11 R3 R5 R8: vector table
        foreach (TBL[i]) begin
            run_cfg(1'b1, TBL[i].fen, TBL[i].fsel, TBL[i].la, TBL[i].lb,
                    TBL[i].pre, TBL[i].oreg, int'(TBL[i].steps));
            read_flags(got);
            check($sformatf("R2 table entry %0d", i), got, TBL[i].expf);
        end

        // R9: second configuration without clearing adds to earlier flags
        run_cfg(1'b1, 1'b1, 3'd1, 8'hFF, 8'hF0, 1'b0, 1'b0, 1);
        run_cfg(1'b0, 1'b1, 3'd6, 8'hFF, 8'hA0, 1'b1, 1'b0, 1);
        read_flags(got);
        check("R9 accumulate", got, 7'b1100011);

        // R10: fault held during shifting sets nothing; order is preserved
        run_cfg(1'b1, 1'b1, 3'd3, 8'hFF, 8'hF0, 1'b0, 1'b0, 1);
        fault_sel_i = 3'd0; fault_en_i = 1'b1;
        read_flags(got);
        fault_en_i = 1'b0;
        check("R10 frozen compare", got, 7'b0001100);

        // R10: chain filled with zeros after a full read
        read_flags(got);
        check("R10 zero fill", got, 7'b0);

        // R7: flag persists across extra healthy steps until cleared
        run_cfg(1'b1, 1'b1, 3'd6, 8'hFF, 8'hF0, 1'b0, 1'b0, 1);
        for (int s = 0; s < 3; s++) strobe();
        wr_ctrl(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00));
        check("R7 sticky flag0", {6'b0, scan_o}, 7'b0);
        wr_ctrl(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00));
        read_flags(got);
        check("R7 sticky", got, 7'b1100000);

        // R7: clear pulse empties flags
        run_cfg(1'b1, 1'b1, 3'd2, 8'hFF, 8'hF0, 1'b0, 1'b0, 1);
        wr_ctrl(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hF0));
        read_flags(got);
        check("R7 clear", got, 7'b0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule